// File: doc/BRIEF.md
# Shared-Cache Victim Selector with Core Partitions

This block decides which way of one set in a shared last-level cache is overwritten when a miss must allocate. The ways of every set are divided into equal, contiguous groups, one group per core. The recency logic outside this block supplies the few least-recent ways as candidates, together with their access-frequency counts and the valid bits of the set. The selector combines that with a record of which ways currently hold a block that a foreign core placed there.

A request carries the core number, the set index, the candidate ways, their counts and the line valid bits. It is accepted on a valid/ready handshake, and the chosen way, together with a code for the rule that chose it, appears on a registered output one cycle later. At that same clock edge the selector updates its record of borrowed ways for the chosen entry. Tag lookup, data storage, counter upkeep and recency ordering all sit outside the block.

Top module: `vsel_victim_select`

## Requirements
- R1: Way w belongs to core floor(w / (NUM_WAYS/NUM_CORES)); with the default 16 ways and 4 cores, core c owns ways 4c to 4c+3.
- R2: If any line of the set is invalid, the victim is the lowest-numbered invalid way, reported with rule code 0.
- R3: Otherwise, if any candidate lies in the requesting core's own group, the victim is the lowest-numbered such candidate, rule code 1.
- R4: Otherwise, if any way in the requester's group (candidate or not) is marked as borrowed by another core, the victim is the lowest-numbered such way, rule code 2.
- R5: Otherwise the victim is the candidate with the smallest frequency count, with ties going to the lowest way number, rule code 3.
- R6: After every accepted request the borrowed mark of the chosen (set, way) becomes 1 if the way lies outside the requester's group and 0 if it lies inside; a mark set by one request is seen by the next request to the same set.
- R7: The victim appears on vic_way with vic_valid high in the cycle after the request is accepted; vic_rule carries 2-bit codes 0 invalid, 1 own, 2 reclaim, 3 frequency.
- R8: While vic_valid is high and vic_ready is low, vic_way and vic_rule stay unchanged and req_ready is low.
- R9: After reset vic_valid is 0, req_ready is 1 and no way is marked as borrowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_core | input | CORE_W | Requesting core number |
| req_set | input | SET_W | Set index |
| req_cands | input | CANDS*WAY_W | Candidate ways, slot s in bits s*WAY_W upward |
| req_freqs | input | CANDS*FREQ_W | Frequency count of each candidate slot |
| req_line_valid | input | NUM_WAYS | Valid bit of each way in the set |
| vic_valid | output | 1 | Victim result present |
| vic_ready | input | 1 | Consumer takes the result |
| vic_way | output | WAY_W | Chosen way |
| vic_rule | output | 2 | Rule that chose the way |

## Verification
The assertions take for granted that the candidate slots of a request name distinct ways and that req_core is below NUM_CORES, since the recency block and the core numbering guarantee both. The bench builds every candidate list as an arithmetic progression with an odd stride modulo 16, which keeps the four slots distinct, and only issues core numbers 0 to 3. Frequency counts and invalid-way positions are derived from loop indices, so that equal counts and single invalid lines occur at known points of the sweep.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

    typedef enum logic [1:0] {
        RULE_INVALID = 2'd0,
        RULE_OWN     = 2'd1,
        RULE_RECLAIM = 2'd2,
        RULE_FREQ    = 2'd3
    } rule_e;

endpackage

// File: rtl/vsel_steal_table.sv
module vsel_steal_table #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 16,
    localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SET_W-1:0]    set_i,
    output logic [NUM_WAYS-1:0] row_o,
    input  logic                wr_en_i,
    input  logic [WAY_W-1:0]    wr_way_i,
    input  logic                wr_val_i
);

    logic [NUM_WAYS-1:0] marks_q [NUM_SETS];
    logic [NUM_WAYS-1:0] marks_d [NUM_SETS];

    assign row_o = marks_q[set_i];

    always_comb begin
        marks_d = marks_q;
        if (wr_en_i) begin
            marks_d[set_i][wr_way_i] = wr_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                marks_q[s] <= '0;
            end
        end else begin
            marks_q <= marks_d;
        end
    end

endmodule

// File: rtl/vsel_victim_pick.sv
module vsel_victim_pick
    import vsel_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_WAYS  = 16,
    parameter int CANDS     = 4,
    parameter int FREQ_W    = 8,
    localparam int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int GROUP    = NUM_WAYS / NUM_CORES
) (
    input  logic [CORE_W-1:0]       core_i,
    input  logic [CANDS*WAY_W-1:0]  cands_i,
    input  logic [CANDS*FREQ_W-1:0] freqs_i,
    input  logic [NUM_WAYS-1:0]     line_valid_i,
    input  logic [NUM_WAYS-1:0]     stolen_row_i,
    output logic [WAY_W-1:0]        way_o,
    output rule_e                   rule_o
);

    function automatic logic [CORE_W-1:0] owner_of(input logic [WAY_W-1:0] w);
        return CORE_W'(int'(w) / GROUP);
    endfunction

    logic              inv_hit, rec_hit, own_hit;
    logic [WAY_W-1:0]  inv_way, rec_way, own_way, low_way;
    logic [FREQ_W-1:0] low_f;

    // invalid lines and reclaimable borrowed ways: lowest index wins
    always_comb begin
        inv_hit = 1'b0;
        inv_way = '0;
        rec_hit = 1'b0;
        rec_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!line_valid_i[w]) begin
                inv_hit = 1'b1;
                inv_way = WAY_W'(w);
            end
            if (stolen_row_i[w] && owner_of(WAY_W'(w)) == core_i) begin
                rec_hit = 1'b1;
                rec_way = WAY_W'(w);
            end
        end
    end

    // candidate scan: own-group candidate and lowest count
    always_comb begin
        logic [WAY_W-1:0]  c_v;
        logic [FREQ_W-1:0] f_v;
        own_hit = 1'b0;
        own_way = '0;
        low_way = cands_i[WAY_W-1:0];
        low_f   = freqs_i[FREQ_W-1:0];
        for (int s = 0; s < CANDS; s++) begin
            c_v = cands_i[s*WAY_W +: WAY_W];
            f_v = freqs_i[s*FREQ_W +: FREQ_W];
            if (owner_of(c_v) == core_i && (!own_hit || c_v < own_way)) begin
                own_hit = 1'b1;
                own_way = c_v;
            end
            if (f_v < low_f || (f_v == low_f && c_v < low_way)) begin
                low_f   = f_v;
                low_way = c_v;
            end
        end
    end

    always_comb begin
        if (inv_hit) begin
            way_o  = inv_way;
            rule_o = RULE_INVALID;
        end else if (own_hit) begin
            way_o  = own_way;
            rule_o = RULE_OWN;
        end else if (rec_hit) begin
            way_o  = rec_way;
            rule_o = RULE_RECLAIM;
        end else begin
            way_o  = low_way;
            rule_o = RULE_FREQ;
        end
    end

endmodule

// File: rtl/vsel_victim_select.sv
module vsel_victim_select
    import vsel_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_WAYS  = 16,
    parameter int NUM_SETS  = 16,
    parameter int CANDS     = 4,
    parameter int FREQ_W    = 8,
    localparam int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int GROUP    = NUM_WAYS / NUM_CORES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [CORE_W-1:0]       req_core,
    input  logic [SET_W-1:0]        req_set,
    input  logic [CANDS*WAY_W-1:0]  req_cands,
    input  logic [CANDS*FREQ_W-1:0] req_freqs,
    input  logic [NUM_WAYS-1:0]     req_line_valid,
    output logic                    vic_valid,
    input  logic                    vic_ready,
    output logic [WAY_W-1:0]        vic_way,
    output logic [1:0]              vic_rule
);

    typedef struct packed {
        logic             valid;
        logic [WAY_W-1:0] way;
        rule_e            rule;
    } out_t;

    function automatic logic [CORE_W-1:0] owner_of(input logic [WAY_W-1:0] w);
        return CORE_W'(int'(w) / GROUP);
    endfunction

    out_t                out_d, out_q;
    logic                accept;
    logic [NUM_WAYS-1:0] steal_row;
    logic [WAY_W-1:0]    pick_way;
    rule_e               pick_rule;
    logic                mark_val;

    assign req_ready = !out_q.valid || vic_ready;
    assign accept    = req_valid && req_ready;
    assign mark_val  = owner_of(pick_way) != req_core;

    vsel_steal_table #(
        .NUM_SETS (NUM_SETS),
        .NUM_WAYS (NUM_WAYS)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (req_set),
        .row_o    (steal_row),
        .wr_en_i  (accept),
        .wr_way_i (pick_way),
        .wr_val_i (mark_val)
    );

    vsel_victim_pick #(
        .NUM_CORES (NUM_CORES),
        .NUM_WAYS  (NUM_WAYS),
        .CANDS     (CANDS),
        .FREQ_W    (FREQ_W)
    ) u_pick (
        .core_i       (req_core),
        .cands_i      (req_cands),
        .freqs_i      (req_freqs),
        .line_valid_i (req_line_valid),
        .stolen_row_i (steal_row),
        .way_o        (pick_way),
        .rule_o       (pick_rule)
    );

    always_comb begin
        out_d = out_q;
        if (out_q.valid && vic_ready) begin
            out_d.valid = 1'b0;
        end
        if (accept) begin
            out_d.valid = 1'b1;
            out_d.way   = pick_way;
            out_d.rule  = pick_rule;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{valid: 1'b0, way: '0, rule: RULE_INVALID};
        end else begin
            out_q <= out_d;
        end
    end

    assign vic_valid = out_q.valid;
    assign vic_way   = out_q.way;
    assign vic_rule  = out_q.rule;

    // R2
    invalid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pick_rule == RULE_INVALID) |-> !req_line_valid[pick_way]);

    // R3
    own_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pick_rule == RULE_OWN) |-> (owner_of(pick_way) == req_core));

    // R4
    reclaim_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pick_rule == RULE_RECLAIM)
            |-> (steal_row[pick_way] && owner_of(pick_way) == req_core));

    // R5
    freq_foreign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pick_rule == RULE_FREQ) |-> (owner_of(pick_way) != req_core));

    // R7
    one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (vic_valid && vic_way == $past(pick_way)));

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_valid && !vic_ready) |=> (vic_valid && $stable(vic_way) && $stable(vic_rule)));

endmodule

// File: tb/vsel_victim_select_bench.sv
`timescale 1ns/1ps
module vsel_victim_select_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_core = '0;
    logic [3:0]  req_set = '0;
    logic [15:0] req_cands = '0;
    logic [31:0] req_freqs = '0;
    logic [15:0] req_line_valid = '1;
    logic        vic_valid;
    logic        vic_ready = 1'b1;
    logic [3:0]  vic_way;
    logic [1:0]  vic_rule;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    bit mark [16][16];

    always #2 clk = ~clk;

    vsel_victim_select u_vsel_victim_select (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_core(req_core), .req_set(req_set),
        .req_cands(req_cands), .req_freqs(req_freqs),
        .req_line_valid(req_line_valid),
        .vic_valid(vic_valid), .vic_ready(vic_ready),
        .vic_way(vic_way), .vic_rule(vic_rule)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // issues one request, compares against the arithmetic model; returns rule
    task automatic run_req(input int core, input int set, input logic [15:0] cands,
                           input logic [31:0] freqs, input logic [15:0] vmask,
                           output int rule_out);
        int ew = -1;
        int er = 0;
        int bf = 256;
        string rq;
        for (int w = 0; w < 16; w++) if (!vmask[w] && ew < 0) ew = w;
        if (ew < 0) begin
            for (int i = 0; i < 4; i++) begin
                int c = int'(cands[i*4 +: 4]);
                if (c / 4 == core && (ew < 0 || c < ew)) begin ew = c; er = 1; end
            end
        end
        if (ew < 0) begin
            for (int w = 0; w < 16; w++)
                if (w / 4 == core && mark[set][w] && ew < 0) begin ew = w; er = 2; end
        end
        if (ew < 0) begin
            er = 3;
            for (int i = 0; i < 4; i++) begin
                int c = int'(cands[i*4 +: 4]);
                int f = int'(freqs[i*8 +: 8]);
                if (f < bf || (f == bf && c < ew)) begin bf = f; ew = c; end
            end
        end
        mark[set][ew] = (ew / 4 != core);
        rq = (er == 0) ? "R2" : (er == 1) ? "R1 R3" : (er == 2) ? "R4 R6" : "R5";
        @(negedge clk);
        req_core = 2'(core); req_set = 4'(set); req_cands = cands;
        req_freqs = freqs; req_line_valid = vmask; req_valid = 1'b1; vic_ready = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        check(vic_valid == 1'b1, "R7 valid", int'(vic_valid), 1);
        check(int'(vic_way) == ew, rq, int'(vic_way), ew);
        check(int'(vic_rule) == er, {rq, " rule"}, int'(vic_rule), er);
        rule_out = int'(vic_rule);
        @(negedge clk);
    endtask

    function automatic logic [15:0] prog(input int base, input int step);
        logic [15:0] r;
        for (int i = 0; i < 4; i++) r[i*4 +: 4] = 4'((base + i * step) % 16);
        return r;
    endfunction

    initial begin
        int rr;
        int sets [3] = '{0, 5, 15};
        for (int s = 0; s < 16; s++) for (int w = 0; w < 16; w++) mark[s][w] = 0;
        repeat (3) @(posedge clk);
        #1;
        // R9
        check(vic_valid == 1'b0, "R9 vic_valid", int'(vic_valid), 0);
        check(req_ready == 1'b1, "R9 req_ready", int'(req_ready), 1);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: no marks after reset -> core 0 with all-foreign candidates uses counts
        run_req(0, 9, prog(8, 1), {8'd40, 8'd30, 8'd30, 8'd60}, 16'hFFFF, rr);
        check(rr == 3, "R9 R5 no mark after reset", rr, 3);

        // sweep
        foreach (sets[k]) begin
            for (int core = 0; core < 4; core++) begin
                for (int p = 0; p < 8; p++) begin
                    logic [31:0] fq;
                    logic [15:0] vm = 16'hFFFF;
                    int st = (p % 2 == 0) ? 5 : 3;
                    for (int i = 0; i < 4; i++)
                        fq[i*8 +: 8] = (p == 3) ? 8'd7 : 8'((p * 37 + i * 91 + sets[k] * 13) % 256);
                    if (p == 6) vm[(core * 3 + sets[k]) % 16] = 1'b0;
                    run_req(core, sets[k], prog(core * 4 + p * 3 + sets[k] + 5, st), fq, vm, rr);
                end
            end
        end

        // R6 R4 directed: borrow then reclaim on set 3
        run_req(1, 3, prog(0, 1), {8'd90, 8'd20, 8'd20, 8'd50}, 16'hFFFF, rr);
        check(rr == 3, "R5 tie to lowest way", rr, 3);
        run_req(0, 3, prog(8, 1), {8'd1, 8'd1, 8'd1, 8'd1}, 16'hFFFF, rr);
        check(rr == 2, "R4 reclaim", rr, 2);
        run_req(0, 3, prog(8, 1), {8'd9, 8'd4, 8'd9, 8'd9}, 16'hFFFF, rr);
        check(rr == 3, "R6 mark cleared", rr, 3);
        // R2: invalid beats own candidate
        run_req(2, 3, prog(8, 1), {8'd9, 8'd4, 8'd9, 8'd9}, 16'hFDFF, rr);
        check(rr == 0, "R2 invalid first", rr, 0);

        // R8 backpressure
        @(negedge clk);
        req_core = 2'd3; req_set = 4'd7; req_cands = prog(12, 1);
        req_freqs = '0; req_line_valid = 16'hFFFF; req_valid = 1'b1; vic_ready = 1'b0;
        @(posedge clk); #1;
        req_cands = prog(0, 1);
        for (int c = 0; c < 3; c++) begin
            @(posedge clk); #1;
            check(vic_valid == 1'b1 && vic_way == 4'd12, "R8 hold way", int'(vic_way), 12);
            check(req_ready == 1'b0, "R8 req_ready low", int'(req_ready), 0);
        end
        @(negedge clk);
        req_valid = 1'b0; vic_ready = 1'b1;
        @(posedge clk); #1;
        check(vic_valid == 1'b0, "R8 drained", int'(vic_valid), 0);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule